// File: doc/BRIEF.md
# Counting Receive-Stream Generator

This peripheral feeds a DMA receive channel with a counting data stream. It has no pins and speaks no line protocol. Software programs one 32-bit setup word that holds three things: an arm bit, a first value and a word count. Once the arm bit is set, the block presents consecutive values on a valid/ready/data channel. It emits exactly one word per completed handshake.

When the final word has been accepted, the block parks in a wait-for-clear state and raises a done flag that software can poll. It re-arms only after software writes the arm bit back to 0. The setup word can be read back. Field changes made while a run is in progress are not used until the next start.

Top module: `tgen_rx_top`

## Requirements
- R1: While rst_ni is low, and right after it is released, rx_valid_o is 0, done_o is 0 and cfg_rdata_o is 0.
- R2: A write with cfg_we_i stores bit 0 (arm), bits [15:8] (count) and bits [31:16] (first value). cfg_rdata_o then returns those fields in the same positions. Bits [7:1] always read 0, whatever was written to them.
- R3: A write that sets the arm bit while the block is idle raises rx_valid_o in the second cycle after the write edge. The count must be nonzero.
- R4: The run emits exactly count words. Their values are first, first+1, ... first+count-1, each taken modulo 2^16 and zero-extended to 32 bits.
- R5: While rx_valid_o is 1 and rx_ready_i is 0, rx_valid_o stays 1 and rx_data_o holds its value.
- R6: The stream advances by one word per cycle in which rx_valid_o and rx_ready_i are both 1. With ready held high, words go out back to back.
- R7: In the cycle after the last word is accepted, rx_valid_o is 0 and done_o is 1.
- R8: A start with count 0 raises done_o without ever asserting rx_valid_o.
- R9: done_o stays 1 until the arm bit is written to 0. It falls in the second cycle after that write edge.
- R10: Writes to the setup word during a run do not change the words being emitted.
- R11: Rewriting the arm bit to 1 while done_o is 1 neither restarts the stream nor clears done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Setup word write strobe |
| cfg_wdata_i | input | 32 | Setup word write data |
| cfg_rdata_o | output | 32 | Setup word readback |
| done_o | output | 1 | Run finished, waiting for the arm bit to be cleared |
| rx_valid_o | output | 1 | Stream word valid |
| rx_ready_i | input | 1 | Stream word accepted by the DMA side |
| rx_data_o | output | 32 | Stream word |

## Verification
The assertions check four behaviours on every cycle:
- valid and data are held during a stall;
- each accepted word is followed by its successor;
- the last acceptance lands in done, as does a zero-count start;
- done stays up while the arm bit stays set, and a write shows up in the readback.

Only the bench's scenarios can show the rest:
- the exact count of words emitted;
- the arm-to-valid and clear-to-idle latencies;
- wraparound of the first value;
- mid-run field writes having no effect.

The bench sweeps these over counts, first values and ready patterns.

// File: rtl/tgen_pkg.sv
package tgen_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_WAIT_CLR
  } tgen_state_e;

  // setup word field positions, fixed by the software view
  localparam int ARM_BIT  = 0;
  localparam int CNT_LSB  = 8;
  localparam int INIT_LSB = 16;
endpackage

// File: rtl/tgen_setup_reg.sv
module tgen_setup_reg
  import tgen_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int INIT_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              arm_o,
  output logic [INIT_W-1:0] init_o,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam int RSV_W = CNT_LSB - ARM_BIT - 1;

  logic              arm_q;
  logic [INIT_W-1:0] init_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q  <= 1'b0;
      init_q <= '0;
      cnt_q  <= '0;
    end else if (we_i) begin
      arm_q  <= wdata_i[ARM_BIT];
      init_q <= wdata_i[INIT_LSB +: INIT_W];
      cnt_q  <= wdata_i[CNT_LSB +: CNT_W];
    end
  end

  assign rdata_o = {init_q, cnt_q, {RSV_W{1'b0}}, arm_q};
  assign arm_o   = arm_q;
  assign init_o  = init_q;
  assign cnt_o   = cnt_q;

  p_wr_readback_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (rdata_o[INIT_LSB +: INIT_W] == $past(wdata_i[INIT_LSB +: INIT_W]))
          && (rdata_o[CNT_LSB +: CNT_W] == $past(wdata_i[CNT_LSB +: CNT_W]))
          && (rdata_o[ARM_BIT] == $past(wdata_i[ARM_BIT])));

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(rdata_o));
endmodule

// File: rtl/tgen_seq_fsm.sv
module tgen_seq_fsm
  import tgen_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int INIT_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic [INIT_W-1:0] init_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              done_o
);
  localparam int PAD_W = DATA_W - INIT_W;

  tgen_state_e       state_q;
  logic [INIT_W-1:0] cur_q;
  logic [CNT_W-1:0]  rem_q;
  logic              last_w;

  assign last_w = (rem_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      rem_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (arm_i) begin
          cur_q   <= init_i;   // fields latched once per run
          rem_q   <= cnt_i;
          state_q <= (cnt_i == '0) ? ST_WAIT_CLR : ST_RUN;
        end
        ST_RUN: if (ready_i) begin
          cur_q <= cur_q + 1'b1;
          rem_q <= rem_q - 1'b1;
          if (last_w) state_q <= ST_WAIT_CLR;
        end
        ST_WAIT_CLR: if (!arm_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign valid_o = (state_q == ST_RUN);
  assign done_o  = (state_q == ST_WAIT_CLR);
  assign data_o  = {{PAD_W{1'b0}}, cur_q};

  p_stall_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(data_o));

  p_next_word_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && ready_i && !last_w |=> valid_o &&
      (data_o[INIT_W-1:0] == INIT_W'($past(data_o[INIT_W-1:0]) + 1'b1)));

  p_last_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && ready_i && last_w |=> done_o && !valid_o);

  p_zero_cnt_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) && arm_i && (cnt_i == '0) |=> done_o && !valid_o);

  p_wait_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && arm_i |=> done_o && !valid_o);
endmodule

// File: rtl/tgen_rx_top.sv
module tgen_rx_top #(
  parameter int DATA_W = 32,
  parameter int INIT_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [31:0]       cfg_wdata_i,
  output logic [31:0]       cfg_rdata_o,
  output logic              done_o,
  output logic              rx_valid_o,
  input  logic              rx_ready_i,
  output logic [DATA_W-1:0] rx_data_o
);
  logic              arm;
  logic [INIT_W-1:0] init_val;
  logic [CNT_W-1:0]  cnt_val;

  tgen_setup_reg #(
    .REG_W (32),
    .INIT_W(INIT_W),
    .CNT_W (CNT_W)
  ) u_setup (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .wdata_i(cfg_wdata_i),
    .rdata_o(cfg_rdata_o),
    .arm_o  (arm),
    .init_o (init_val),
    .cnt_o  (cnt_val)
  );

  tgen_seq_fsm #(
    .DATA_W(DATA_W),
    .INIT_W(INIT_W),
    .CNT_W (CNT_W)
  ) u_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .arm_i  (arm),
    .init_i (init_val),
    .cnt_i  (cnt_val),
    .ready_i(rx_ready_i),
    .valid_o(rx_valid_o),
    .data_o (rx_data_o),
    .done_o (done_o)
  );
endmodule

// File: tb/tb_tgen_rx_top.sv
`timescale 1ns/1ps
module tb_tgen_rx_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        done, rx_valid, rx_ready = 1'b0;
  logic [31:0] rx_data;
  int          checks = 0, failures = 0, cyc = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  tgen_rx_top dut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .cfg_rdata_o(cfg_rdata), .done_o(done), .rx_valid_o(rx_valid),
    .rx_ready_i(rx_ready), .rx_data_o(rx_data)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic pick(input int pat, input int t);
    case (pat)
      0: return 1'b1;
      1: return t[0];
      default: begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0];
      end
    endcase
  endfunction

  task automatic cfg_write(input logic [31:0] d);
    cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_xfer(input logic [15:0] init, input int cnt, input int pat, input bit midw);
    int n = 0, t = 0;
    logic [15:0] exp = init;
    bit wrote = 0, stalled = 0;
    cfg_write({init, 8'(cnt), 8'h01});
    while (!done && t < 3000) begin
      cfg_we = 1'b0;
      if (midw && n == 2 && !wrote) begin
        cfg_we = 1'b1; cfg_wdata = {16'h5A5A, 8'd1, 8'h01}; wrote = 1;
      end
      if (stalled) chk(rx_valid, "R5 valid held", 32'(rx_valid), 1);
      rx_ready = pick(pat, t);
      stalled = rx_valid && !rx_ready;
      if (rx_valid) begin
        chk(rx_data == {16'h0, exp}, midw ? "R10 data" : "R4 data", rx_data, {16'h0, exp});
        if (rx_ready) begin exp++; n++; end
      end
      t++;
      @(negedge clk);
    end
    cfg_we = 1'b0; rx_ready = 1'b0;
    chk(t < 3000, "R6 progress", t, 3000);
    chk(n == cnt, cnt == 0 ? "R8 no words" : "R4 count", n, cnt);
    chk(!rx_valid && done, "R7 done after last", {rx_valid, done}, 2'b01);
    cfg_write({init, 8'(cnt), 8'h00});
    chk(done, "R9 done held until fsm sees clear", 32'(done), 1);
    @(negedge clk);
    chk(!done, "R9 done falls", 32'(done), 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        failures++; checks++;
        $display("FAIL watchdog actual=%0d expected<150000", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!rx_valid && !done && cfg_rdata == 0, "R1 in reset", {rx_valid, done}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!rx_valid && !done && cfg_rdata == 0, "R1 after reset", cfg_rdata, 0);

    // R2 readback, reserved bits masked, arm clear so nothing starts
    cfg_write(32'hA5C3_7EFE);
    chk(cfg_rdata == 32'hA5C3_7E00, "R2 readback", cfg_rdata, 32'hA5C3_7E00);
    @(negedge clk);
    chk(!rx_valid && !done, "R2 no start with arm 0", {rx_valid, done}, 0);

    // R3 arm-to-valid latency
    cfg_write({16'h0010, 8'd2, 8'h01});
    chk(!rx_valid, "R3 not yet valid", 32'(rx_valid), 0);
    @(negedge clk);
    chk(rx_valid && rx_data == 32'h10, "R3 valid second cycle", rx_data, 32'h10);
    rx_ready = 1'b1;
    @(negedge clk);
    chk(rx_valid && rx_data == 32'h11, "R6 back to back", rx_data, 32'h11);
    @(negedge clk);
    rx_ready = 1'b0;
    chk(done && !rx_valid, "R7 done next cycle", {rx_valid, done}, 2'b01);
    // R11 rewrite arm while waiting
    cfg_write({16'h0010, 8'd2, 8'h01});
    repeat (4) begin
      @(negedge clk);
      chk(done && !rx_valid, "R11 no restart", {rx_valid, done}, 2'b01);
    end
    cfg_write(32'h0);
    @(negedge clk);
    chk(!done, "R9 idle after clear", 32'(done), 0);

    // sweeps over counts, first values and ready patterns
    for (int p = 0; p < 3; p++)
      for (int c = 0; c <= 12; c++) begin
        run_xfer(16'h0000, c, p, 0);
        run_xfer(16'h1234, c, p, 0);
        run_xfer(16'hFFF9, c, p, 0);   // wraps modulo 2^16
      end
    run_xfer(16'h7F00, 255, 2, 0);
    for (int p = 0; p < 3; p++) run_xfer(16'h0200, 9, p, 1);   // R10 mid-run writes

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule